// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block connects a small byte-wide register window to the pins of an 8-bit raw NAND flash device. Software controls the flash almost entirely by hand. One control byte (the mode register) sets the command-latch, address-latch, chip-enable and write-protect pins, and it also carries a two-bit command for a separate error-correction engine. Writing the data port drives one byte onto the flash bus with a single write strobe. Reading the data port fires a single read strobe and returns the byte the flash placed on the bus.

Two further bytes form the interrupt logic: a pending-event byte and a mask byte. Bit 7 of the mask is a global gate. The interrupt request is high only when that gate is set and at least one masked pending bit is set. The pending byte is plain read/write. Every data write also clears all of its bits except bit 0.

Flash cycles are run by a small sequencer with five states:
- `SEQ_IDLE`: ready for a request.
- `SEQ_WR_STROBE`: write strobe low, data driven.
- `SEQ_WR_HOLD`: strobe released, data still driven for one cycle.
- `SEQ_RD_STROBE`: read strobe low.
- `SEQ_RD_RECOVER`: strobe released, response presented.

Its transitions are:
- IDLE to WR_STROBE when a data write is accepted.
- IDLE to RD_STROBE when a data read is accepted.
- WR_STROBE to WR_HOLD after `STROBE_CYCLES` cycles.
- WR_HOLD to IDLE after one cycle.
- RD_STROBE to RD_RECOVER after `STROBE_CYCLES` cycles, capturing the bus.
- RD_RECOVER to IDLE after one cycle.

Register accesses finish while the sequencer stays in IDLE.

Top module: `nfc_regif`

## Requirements
- R1: After reset the mode, pending and mask bytes are 0x00. Chip-enable (active low) is high, and the CLE, ALE, WP, interrupt and ECC strobe outputs are low. Both flash strobes are high, the data-bus enable is low, and `req_ready` is high.
- R2: A write of value v to offset 4 sets the pins one cycle later: CLE = v[0], ALE = v[1], chip-enable low exactly when v[4] = 1, WP = v[7].
- R3: The ECC command is mode bits [6:5]. Value 01 pulses both `ecc_en_pulse` and `ecc_rst_pulse`, and value 11 pulses only `ecc_rst_pulse`. Each pulse lasts one cycle, in the cycle after the mode write. Values 00 and 10 pulse nothing.
- R4: A read of offset 4 returns the last mode value written.
- R5: A read of offset 5 always returns 0x14, and a write to offset 5 changes nothing.
- R6: A write to a data offset produces exactly one low pulse on `fl_we_n` lasting `STROBE_CYCLES` cycles, with the byte on `fl_io_out`. `fl_io_oe` is high for those cycles plus one hold cycle, and `fl_re_n` stays high.
- R7: A data write leaves the pending byte equal to its previous value AND 0x01.
- R8: A read of a data offset produces exactly one low pulse on `fl_re_n` lasting `STROBE_CYCLES` cycles, with `fl_io_oe` low throughout. It returns the bus value captured in the last strobe cycle.
- R9: Offsets 0, 1, 2 and 3 all act as the same data port.
- R10: Offsets 6 (pending) and 7 (mask) read back the last value written, and a write replaces the whole byte.
- R11: `irq` equals mask[7] AND ((mask AND pending) != 0), updated one cycle after any pending or mask write.
- R12: `req_ready` is low for the whole of a flash cycle and no request is accepted then. Register reads answer with `rsp_valid` one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted on this edge when high |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_wp | output | 1 | Write-protect pin |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_io_out | output | 8 | Flash bus drive value |
| fl_io_oe | output | 1 | Flash bus drive enable |
| fl_io_in | input | 8 | Flash bus sampled value |
| ecc_en_pulse | output | 1 | ECC enable strobe |
| ecc_rst_pulse | output | 1 | ECC reset strobe |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted mode byte shows up on the CLE, ALE, chip-enable and WP pins in the very next cycle, and a readback of offset 4 exposes it. A sequencer stuck in the wrong state shows as a strobe pulse of the wrong width or count, or a bus enable during a read, within one flash cycle. The same fault also shows as `req_ready` failing to return. A wrong pending or mask byte shows on `irq` one cycle after the write that should have set it, and the bench sweeps the full mask range against several pending patterns to catch it.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] OFF_MODE    = 3'd4;
    localparam logic [REG_ADDR_W-1:0] OFF_STATUS  = 3'd5;
    localparam logic [REG_ADDR_W-1:0] OFF_PENDING = 3'd6;
    localparam logic [REG_ADDR_W-1:0] OFF_MASK    = 3'd7;

    localparam int MODE_BIT_CLE  = 0;
    localparam int MODE_BIT_ALE  = 1;
    localparam int MODE_BIT_CE   = 4;
    localparam int MODE_ECC_LO   = 5;
    localparam int MODE_BIT_WP   = 7;
    localparam int MASK_BIT_GATE = 7;

    typedef enum logic [1:0] {
        ECC_CMD_NONE   = 2'b00,
        ECC_CMD_ENABLE = 2'b01,
        ECC_CMD_READ   = 2'b10,
        ECC_CMD_RESET  = 2'b11
    } ecc_cmd_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WR_STROBE,
        SEQ_WR_HOLD,
        SEQ_RD_STROBE,
        SEQ_RD_RECOVER
    } seq_state_e;

endpackage

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int STROBE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [DATA_W-1:0] fl_io_in,
    output logic              idle,
    output logic              fl_we_n,
    output logic              fl_re_n,
    output logic [DATA_W-1:0] fl_io_out,
    output logic              fl_io_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_byte
);

    localparam int CNT_W = $clog2(STROBE_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYCLES - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] byte_q;
    logic              done_q;
    logic              strobe_last;

    assign strobe_last = (cnt_q == CNT_LAST);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_wr)      state_d = SEQ_WR_STROBE;
                else if (start_rd) state_d = SEQ_RD_STROBE;
            end
            SEQ_WR_STROBE:  if (strobe_last) state_d = SEQ_WR_HOLD;
            SEQ_WR_HOLD:    state_d = SEQ_IDLE;
            SEQ_RD_STROBE:  if (strobe_last) state_d = SEQ_RD_RECOVER;
            SEQ_RD_RECOVER: state_d = SEQ_IDLE;
            default:        state_d = SEQ_IDLE;
        endcase
    end

    // state register, strobe counter, data latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            byte_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == SEQ_RD_STROBE) && strobe_last;
            if (state_q == SEQ_IDLE) begin
                cnt_q <= '0;
                if (start_wr) byte_q <= wr_byte;
            end else if ((state_q == SEQ_WR_STROBE) || (state_q == SEQ_RD_STROBE)) begin
                cnt_q <= strobe_last ? '0 : cnt_q + 1'b1;
                if ((state_q == SEQ_RD_STROBE) && strobe_last) byte_q <= fl_io_in;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        idle     = 1'b0;
        fl_we_n  = 1'b1;
        fl_re_n  = 1'b1;
        fl_io_oe = 1'b0;
        unique case (state_q)
            SEQ_IDLE:       idle = 1'b1;
            SEQ_WR_STROBE: begin
                fl_we_n  = 1'b0;
                fl_io_oe = 1'b1;
            end
            SEQ_WR_HOLD:    fl_io_oe = 1'b1;
            SEQ_RD_STROBE:  fl_re_n = 1'b0;
            SEQ_RD_RECOVER: idle = 1'b0;
            default:        idle = 1'b0;
        endcase
    end

    assign fl_io_out = byte_q;
    assign rd_byte   = byte_q;
    assign rd_done   = done_q;

    // R6 / R8: the two strobes never overlap
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_re_n));

    // R8: bus never driven while the read strobe is low
    p_no_drive_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> !fl_io_oe);

    // R6: driven byte stays put inside a write strobe
    p_byte_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$fell(fl_we_n)) |-> $stable(fl_io_out));

    // R6: bus still driven in the cycle the strobe rises
    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> fl_io_oe);

endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
    import nfc_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter logic [DATA_W-1:0] STATUS_VALUE = 8'h14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  data_wr,
    output logic [DATA_W-1:0]     mode,
    output logic [DATA_W-1:0]     rd_val,
    output logic                  ecc_en_pulse,
    output logic                  ecc_rst_pulse,
    output logic                  irq
);

    logic [DATA_W-1:0] mode_q, pend_q, mask_q;
    logic              ecc_en_q, ecc_rst_q;
    ecc_cmd_e          cmd;

    assign cmd = ecc_cmd_e'(wdata[MODE_ECC_LO +: 2]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            pend_q    <= '0;
            mask_q    <= '0;
            ecc_en_q  <= 1'b0;
            ecc_rst_q <= 1'b0;
        end else begin
            ecc_en_q  <= 1'b0;
            ecc_rst_q <= 1'b0;
            if (wr_en) begin
                unique case (addr)
                    OFF_MODE: begin
                        mode_q <= wdata;
                        unique case (cmd)
                            ECC_CMD_ENABLE: begin
                                ecc_en_q  <= 1'b1;
                                ecc_rst_q <= 1'b1;
                            end
                            ECC_CMD_RESET:  ecc_rst_q <= 1'b1;
                            ECC_CMD_READ:   ecc_rst_q <= 1'b0;
                            ECC_CMD_NONE:   ecc_rst_q <= 1'b0;
                            default:        ecc_rst_q <= 1'b0;
                        endcase
                    end
                    OFF_PENDING: pend_q <= wdata;
                    OFF_MASK:    mask_q <= wdata;
                    default:     mode_q <= mode_q;
                endcase
            end else if (data_wr) begin
                pend_q <= pend_q & DATA_W'(1);
            end
        end
    end

    always_comb begin
        case (addr)
            OFF_MODE:    rd_val = mode_q;
            OFF_STATUS:  rd_val = STATUS_VALUE;
            OFF_PENDING: rd_val = pend_q;
            OFF_MASK:    rd_val = mask_q;
            default:     rd_val = '0;
        endcase
    end

    assign mode          = mode_q;
    assign ecc_en_pulse  = ecc_en_q;
    assign ecc_rst_pulse = ecc_rst_q;
    assign irq           = mask_q[MASK_BIT_GATE] && |(mask_q & pend_q);

    // R7: a data write leaves only bit 0 of the pending byte
    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(data_wr) |-> (pend_q[DATA_W-1:1] == '0));

    // R3: enable command always carries a reset
    p_ecc_en_has_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en_pulse |-> ecc_rst_pulse);

    // R3: ECC strobes only follow a mode write
    p_ecc_after_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_rst_pulse |-> $past(wr_en && (addr == OFF_MODE)));

    // R4: mode holds the byte written
    p_mode_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (addr == OFF_MODE)) |-> (mode == $past(wdata)));

    // R11: no interrupt without the global gate
    p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mask_q[MASK_BIT_GATE]);

endmodule

// File: rtl/nfc_regif.sv
module nfc_regif
    import nfc_pkg::*;
#(
    parameter int                DATA_W        = 8,
    parameter int                STROBE_CYCLES = 2,
    parameter logic [DATA_W-1:0] STATUS_VALUE  = 8'h14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  fl_cle,
    output logic                  fl_ale,
    output logic                  fl_ce_n,
    output logic                  fl_wp,
    output logic                  fl_we_n,
    output logic                  fl_re_n,
    output logic [DATA_W-1:0]     fl_io_out,
    output logic                  fl_io_oe,
    input  logic [DATA_W-1:0]     fl_io_in,
    output logic                  ecc_en_pulse,
    output logic                  ecc_rst_pulse,
    output logic                  irq
);

    logic              seq_idle, accept, is_data;
    logic              start_wr, start_rd, reg_wr, reg_rd;
    logic              rd_done;
    logic [DATA_W-1:0] rd_byte, reg_val, mode;
    logic              reg_rsp_q;
    logic [DATA_W-1:0] reg_data_q;

    assign accept   = req_valid && seq_idle;
    assign is_data  = !req_addr[REG_ADDR_W-1];
    assign start_wr = accept && req_write && is_data;
    assign start_rd = accept && !req_write && is_data;
    assign reg_wr   = accept && req_write && !is_data;
    assign reg_rd   = accept && !req_write && !is_data;

    nfc_regs #(
        .DATA_W       (DATA_W),
        .STATUS_VALUE (STATUS_VALUE)
    ) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_wr),
        .addr          (req_addr),
        .wdata         (req_wdata),
        .data_wr       (start_wr),
        .mode          (mode),
        .rd_val        (reg_val),
        .ecc_en_pulse  (ecc_en_pulse),
        .ecc_rst_pulse (ecc_rst_pulse),
        .irq           (irq)
    );

    nfc_seq #(
        .DATA_W        (DATA_W),
        .STROBE_CYCLES (STROBE_CYCLES)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .wr_byte   (req_wdata),
        .fl_io_in  (fl_io_in),
        .idle      (seq_idle),
        .fl_we_n   (fl_we_n),
        .fl_re_n   (fl_re_n),
        .fl_io_out (fl_io_out),
        .fl_io_oe  (fl_io_oe),
        .rd_done   (rd_done),
        .rd_byte   (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rsp_q  <= 1'b0;
            reg_data_q <= '0;
        end else begin
            reg_rsp_q <= reg_rd;
            if (reg_rd) reg_data_q <= reg_val;
        end
    end

    assign req_ready = seq_idle;
    assign rsp_valid = reg_rsp_q || rd_done;
    assign rsp_rdata = rd_done ? rd_byte : reg_data_q;

    assign fl_cle  = mode[MODE_BIT_CLE];
    assign fl_ale  = mode[MODE_BIT_ALE];
    assign fl_ce_n = !mode[MODE_BIT_CE];
    assign fl_wp   = mode[MODE_BIT_WP];

    // R12: no strobe while ready for a new request
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_we_n && fl_re_n && !fl_io_oe));

    // R12: register reads answer on the next cycle
    p_reg_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> rsp_valid);

    // R2: chip-enable follows the mode write
    p_ce_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && (req_addr == OFF_MODE)) |-> (fl_ce_n == !$past(req_wdata[MODE_BIT_CE])));

endmodule

// File: tb/nfc_regif_tb_top.sv
module nfc_regif_tb_top;

    localparam int STROBE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] flash_byte = '0;
    logic       req_ready, rsp_valid;
    logic [7:0] rsp_rdata, fl_io_out;
    logic       fl_cle, fl_ale, fl_ce_n, fl_wp, fl_we_n, fl_re_n, fl_io_oe;
    logic       ecc_en_pulse, ecc_rst_pulse, irq;

    int checks = 0, errors = 0;
    bit done = 0;

    int we_low = 0, re_low = 0, oe_cyc = 0, we_pulses = 0, re_pulses = 0;
    logic [7:0] we_byte = '0;
    logic prev_we = 1'b1, prev_re = 1'b1;

    always #4 clk = ~clk;

    nfc_regif #(.STROBE_CYCLES(STROBE)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fl_cle(fl_cle),
        .fl_ale(fl_ale), .fl_ce_n(fl_ce_n), .fl_wp(fl_wp), .fl_we_n(fl_we_n),
        .fl_re_n(fl_re_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
        .fl_io_in(flash_byte), .ecc_en_pulse(ecc_en_pulse),
        .ecc_rst_pulse(ecc_rst_pulse), .irq(irq)
    );

    // flash pin monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n) begin we_low++; we_byte = fl_io_out; end
            if (!fl_re_n) re_low++;
            if (fl_io_oe) oe_cyc++;
            if (prev_we && !fl_we_n) we_pulses++;
            if (prev_re && !fl_re_n) re_pulses++;
        end
        prev_we = fl_we_n;
        prev_re = fl_re_n;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        int guard = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
        d = rsp_rdata;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int w0, wl, r0, rl, o0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ce_n", fl_ce_n, 1);
        check("R1 cle/ale/wp", {fl_cle, fl_ale, fl_wp}, 0);
        check("R1 strobes", {fl_we_n, fl_re_n, fl_io_oe}, 3'b110);
        check("R1 irq/ecc", {irq, ecc_en_pulse, ecc_rst_pulse}, 0);
        check("R1 ready", req_ready, 1);
        reg_read(3'd4, rd); check("R1 mode", rd, 0);
        reg_read(3'd6, rd); check("R1 pending", rd, 0);
        reg_read(3'd7, rd); check("R1 mask", rd, 0);

        // R2 R3 R4: full mode sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] m;
            m = 8'(v);
            reg_write(3'd4, m);
            check("R2 cle", fl_cle, m[0]);
            check("R2 ale", fl_ale, m[1]);
            check("R2 ce_n", fl_ce_n, !m[4]);
            check("R2 wp", fl_wp, m[7]);
            check("R3 ecc_en", ecc_en_pulse, m[6:5] == 2'b01);
            check("R3 ecc_rst", ecc_rst_pulse, (m[6:5] == 2'b01) || (m[6:5] == 2'b11));
            reg_read(3'd4, rd);
            check("R4 mode readback", rd, v);
            check("R3 pulse one cycle", ecc_rst_pulse, 0);
        end

        // R5: status constant and write-ignored
        reg_write(3'd4, 8'h93);
        reg_write(3'd5, 8'hAA);
        reg_read(3'd5, rd); check("R5 status", rd, 8'h14);
        reg_read(3'd4, rd); check("R5 mode untouched", rd, 8'h93);
        check("R5 pins untouched", {fl_wp, fl_ce_n, fl_ale, fl_cle}, 4'b1011);

        // R10 R11: mask x pending sweep
        for (int mk = 0; mk < 256; mk++) begin
            for (int k = 0; k < 9; k++) begin
                logic [7:0] p;
                p = (k == 8) ? 8'hFF : 8'(1 << k);
                if (k == 0) p = 8'h00;
                reg_write(3'd7, 8'(mk));
                reg_write(3'd6, p);
                check("R11 irq", irq, mk[7] && ((8'(mk) & p) != 0));
                if (k == 4) begin
                    reg_read(3'd6, rd); check("R10 pending readback", rd, p);
                    reg_read(3'd7, rd); check("R10 mask readback", rd, mk);
                end
            end
        end

        // R6 R7 R9 R12: data write sweep
        for (int b = 0; b < 256; b++) begin
            reg_write(3'd6, 8'(b));
            w0 = we_pulses; wl = we_low; r0 = re_low; o0 = oe_cyc;
            reg_write(3'(b % 4), 8'(b) ^ 8'h5A);
            check("R12 busy during write", req_ready, 0);
            wait_idle();
            check("R6 one we pulse", we_pulses - w0, 1);
            check("R6 we width", we_low - wl, STROBE);
            check("R6 R9 byte", we_byte, 8'(b) ^ 8'h5A);
            check("R6 oe cycles", oe_cyc - o0, STROBE + 1);
            check("R6 no read strobe", re_low - r0, 0);
            reg_read(3'd6, rd);
            check("R7 pending cleared", rd, b & 1);
        end

        // R8 R9 R12: data read sweep
        for (int b = 0; b < 256; b++) begin
            flash_byte = 8'(b) ^ 8'hC3;
            r0 = re_pulses; rl = re_low; w0 = we_low; o0 = oe_cyc;
            reg_read(3'(b % 4), rd);
            check("R8 R9 read data", rd, 8'(b) ^ 8'hC3);
            wait_idle();
            check("R8 one re pulse", re_pulses - r0, 1);
            check("R8 re width", re_low - rl, STROBE);
            check("R8 no drive", oe_cyc - o0, 0);
            check("R8 no write strobe", we_low - w0, 0);
        end

        // R12: register read answers one cycle later
        wait_idle();
        req_valid = 1'b1; req_write = 1'b0; req_addr = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 rsp timing", rsp_valid, 1);
        check("R12 rsp data", rsp_rdata, 8'h14);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule